// File: doc/BRIEF.md
# Package Idle State Resolver

This block chooses the idle state for a whole package. Each of `NUM_CORES` cores reports its current idle state as a 2-bit code. The block takes the shallowest of these codes as the package request. It then limits that request by a platform grant level and registers the result as the package state.

The platform can withhold deeper states. In that case the package settles at the grant level while individual cores stay in deeper states. The package may move from any state to any other in one step; it does not have to pass through C0.

A one-cycle change strobe marks every clock edge at which the registered package state takes a new value. Downstream sequencing logic can act on that strobe instead of comparing states itself.

Top module: `pkg_idle_resolver`

## Requirements
- R1: The package request is the numerically smallest (shallowest) state code among all `NUM_CORES` core inputs. Core k occupies bits [2k+1:2k] of `core_cstate`.
- R2: State codes are 2 bits wide: 0 = C0 (active), 1 = C1/C1E, 2 = C3, 3 = C6. The order from shallow to deep is the numeric order.
- R3: The resolved state is the smaller of the package request and `plat_grant`.
- R4: When `plat_grant` is smaller than every core code, the package state equals `plat_grant`. Cores that are deeper than the grant have no effect on the output.
- R5: `pkg_change` is high for exactly the one cycle in which `pkg_cstate` has just taken a value different from its previous one. It is low in every other cycle, including cycles where the inputs change but the resolved value does not.
- R6: While `rst` is high, at the next clock edge `pkg_cstate` becomes 0 (C0) and `pkg_change` becomes 0.
- R7: The package moves directly between any two states, for example from C6 to C1 or from C1 to C3, with no intermediate C0 cycle.
- R8: `pkg_cstate` and `pkg_change` are registered. They reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_cstate | input | 2*NUM_CORES | Packed per-core idle state codes, core k at [2k+1:2k] |
| plat_grant | input | 2 | Deepest package state the platform currently allows |
| pkg_cstate | output | 2 | Registered resolved package state |
| pkg_change | output | 1 | One-cycle pulse when pkg_cstate takes a new value |

## Verification
The properties assume that the inputs are stable around each rising edge and that every 2-bit code is legal. Because all four codes are valid states, no input value is excluded. The properties rely on one cycle of history after reset, which is tracked by an arming flag in the checker.

The random stimulus draws every core code and the grant uniformly across all four values. It also holds inputs steady for some cycles, so that the strobe can be seen falling back low. Directed cases place the grant below all cores, make direct jumps between deep states, and assert reset mid-run.

// File: rtl/pkg_idle_types.sv
package pkg_idle_types;

  localparam int CST_W = 2;

  typedef enum logic [CST_W-1:0] {
    CST_C0 = 2'd0,
    CST_C1 = 2'd1,
    CST_C3 = 2'd2,
    CST_C6 = 2'd3
  } cstate_e;

  // shallower of two state codes (numeric minimum)
  function automatic logic [CST_W-1:0] cst_shallower(
    input logic [CST_W-1:0] a,
    input logic [CST_W-1:0] b
  );
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/idle_min_tree.sv
module idle_min_tree
  import pkg_idle_types::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic [NUM_IN*CST_W-1:0] codes,
  output logic [CST_W-1:0]        shallowest
);

  localparam int LEVELS = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int LEAVES = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
    localparam int WIDTH = LEAVES >> l;
    logic [CST_W-1:0] v [WIDTH];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < WIDTH; i++) begin : g_in
        if (i < NUM_IN) begin : g_real
          assign v[i] = codes[i*CST_W +: CST_W];
        end else begin : g_pad
          // deepest code is the identity for a minimum
          assign v[i] = CST_C6;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
        assign v[i] = cst_shallower(g_lv[l-1].v[2*i], g_lv[l-1].v[2*i+1]);
      end
    end
  end

  assign shallowest = g_lv[LEVELS].v[0];

endmodule

// File: rtl/idle_cap_reg.sv
module idle_cap_reg
  import pkg_idle_types::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CST_W-1:0] request,
  input  logic [CST_W-1:0] grant,
  output logic [CST_W-1:0] state_q,
  output logic             change_q
);

  logic [CST_W-1:0] capped;

  assign capped = cst_shallower(request, grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CST_C0;
      change_q <= 1'b0;
    end else begin
      state_q  <= capped;
      change_q <= (capped != state_q);
    end
  end

endmodule

// File: rtl/pkg_idle_resolver.sv
module pkg_idle_resolver
  import pkg_idle_types::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CORES*CST_W-1:0] core_cstate,
  input  logic [CST_W-1:0]           plat_grant,
  output logic [CST_W-1:0]           pkg_cstate,
  output logic                       pkg_change
);

  logic [CST_W-1:0] core_req;

  idle_min_tree #(.NUM_IN(NUM_CORES)) u_tree (
    .codes      (core_cstate),
    .shallowest (core_req)
  );

  idle_cap_reg u_cap (
    .clk      (clk),
    .rst      (rst),
    .request  (core_req),
    .grant    (plat_grant),
    .state_q  (pkg_cstate),
    .change_q (pkg_change)
  );

endmodule

// File: rtl/pkg_idle_resolver_chk.sv
module pkg_idle_resolver_chk
  import pkg_idle_types::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_CORES*CST_W-1:0] core_cstate,
  input logic [CST_W-1:0]           plat_grant,
  input logic [CST_W-1:0]           pkg_cstate,
  input logic                       pkg_change
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R3, R4: never deeper than the grant seen one edge earlier
  p_within_grant_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> pkg_cstate <= $past(plat_grant));

  // R1: never deeper than any single core
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    p_within_core_r1: assert property (@(posedge clk) disable iff (rst)
      armed |-> pkg_cstate <= $past(core_cstate[k*CST_W +: CST_W]));
  end

  // R5: strobe exactly when the state moved
  p_strobe_change_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pkg_change == (pkg_cstate != $past(pkg_cstate))));

  // R6: reset drives C0 and a quiet strobe
  p_reset_value_r6: assert property (@(posedge clk)
    rst |=> (pkg_cstate == CST_C0) && !pkg_change);

  // R8: steady inputs give a steady state with no strobe
  p_hold_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && $stable(core_cstate) && $stable(plat_grant) && !$past(rst))
      |=> $stable(pkg_cstate) && !pkg_change);

endmodule

bind pkg_idle_resolver pkg_idle_resolver_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/pkg_idle_resolver_test.sv
`timescale 1ns/1ps
module pkg_idle_resolver_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2*N-1:0] cores = '0;
  logic [1:0]   grant = '0;
  logic [1:0]   st;
  logic         chg;

  int checks = 0;
  int errors = 0;
  logic [1:0] prev_exp = 2'd0;
  bit done = 0;

  always #4 clk = ~clk;

  pkg_idle_resolver #(.NUM_CORES(N)) uut (
    .clk(clk), .rst(rst), .core_cstate(cores), .plat_grant(grant),
    .pkg_cstate(st), .pkg_change(chg)
  );

  function automatic logic [1:0] exp_state(input logic [2*N-1:0] c, input logic [1:0] g);
    logic [1:0] m = 2'd3;
    for (int i = 0; i < N; i++) if (c[2*i +: 2] < m) m = c[2*i +: 2];
    return (g < m) ? g : m;
  endfunction

  task automatic check(input string req, input logic [1:0] a_st, input logic a_chg,
                       input logic [1:0] e_st, input logic e_chg);
    checks++;
    if (a_st !== e_st || a_chg !== e_chg) begin
      errors++;
      $display("FAIL %s: state=%0d change=%0d expected state=%0d change=%0d",
               req, a_st, a_chg, e_st, e_chg);
    end
  endtask

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic step(input string req, input logic [2*N-1:0] c, input logic [1:0] g);
    logic [1:0] e;
    cores = c; grant = g;
    @(negedge clk);
    e = exp_state(c, g);
    check(req, st, chg, e, e != prev_exp);
    prev_exp = e;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6", st, chg, 2'd0, 1'b0);
    prev_exp = 2'd0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1/R2: shallowest core wins with full grant
    step("R1", {2'd3, 2'd2, 2'd3, 2'd3}, 2'd3);
    step("R1", {2'd3, 2'd3, 2'd3, 2'd3}, 2'd3);
    step("R2", {2'd1, 2'd3, 2'd2, 2'd3}, 2'd3);
    // R5: same result with other inputs, no strobe
    step("R5", {2'd3, 2'd1, 2'd2, 2'd2}, 2'd2);
    // R4: grant below all cores
    step("R4", {2'd3, 2'd3, 2'd3, 2'd3}, 2'd0);
    step("R4", {2'd3, 2'd2, 2'd3, 2'd3}, 2'd1);
    // R3: grant deeper than request
    step("R3", {2'd3, 2'd2, 2'd3, 2'd3}, 2'd3);
    // R7: direct jumps without C0
    step("R7", {2'd3, 2'd3, 2'd3, 2'd3}, 2'd3);
    step("R7", {2'd1, 2'd3, 2'd3, 2'd3}, 2'd3);
    step("R7", {2'd2, 2'd3, 2'd2, 2'd3}, 2'd3);
    // R8: holding inputs keeps state, strobe drops
    step("R8", {2'd2, 2'd3, 2'd2, 2'd3}, 2'd3);
    step("R1", {2'd0, 2'd3, 2'd3, 2'd3}, 2'd3);
    // reset mid-run from a deep state
    step("R6", {2'd3, 2'd3, 2'd3, 2'd3}, 2'd3);
    do_reset();
    // random mix with occasional holds
    for (int n = 0; n < 600; n++) begin
      logic [2*N-1:0] c;
      logic [1:0] g;
      if (($urandom % 4) == 0) begin
        c = cores; g = grant;
      end else begin
        c = $urandom; g = $urandom;
      end
      step("R3", c, g);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule